// File: doc/BRIEF.md
# Error-Status Register File with Per-Offset Access Policies

This block is a bank of 64-bit control and status registers reached over a simple single-cycle request bus. Every implemented word carries one fixed access policy: plain read/write, read-only, write-one-to-clear, clear-on-any-write, write through a field mask, or write-stores-zero. Hardware-side inputs set sticky error bits and capture error log words, so software can read the bank, acknowledge events and rearm logging without losing concurrent hardware events.

The register index is the byte offset shifted right by three. Byte offset 0x08 holds the identification word and 0x10 the capability word (both read-only constants). Offset 0x18 is the control word and 0x20 the scratch word (both read/write). Offsets 0x28 and 0x30 are primary error status A and B (write-one-to-clear). Offset 0x38 is secondary error status (clear-on-any-write), and 0x40 and 0x48 are error log words 0 and 1 (clear-on-any-write). Offset 0x50 is the masked field word, 0x58 the trap capture word (write-stores-zero), and 0x60 the live status mirror (read-only).

Every other offset is unmapped. That includes 0x00, everything from 0x68 up, and any offset whose low three bits are not zero. Reads of an unmapped offset return all ones.

The bus front end is a two-state machine. BUS_IDLE is left for BUS_RESP when a read is requested (transition IDLE_TO_RESP). BUS_RESP stays in BUS_RESP on a back-to-back read (RESP_TO_RESP) and returns to BUS_IDLE otherwise (RESP_TO_IDLE). BUS_IDLE stays in BUS_IDLE when no read arrives (IDLE_HOLD). The response is valid while the machine is in BUS_RESP.

Top module: `errcsr_file`

## Requirements
- R1: After reset, rsp_valid is 0. Every register reads as zero except the identification word (ID_WORD) and the capability word (CAP_WORD).
- R2: A read request (req_valid=1, req_write=0) produces rsp_valid=1 one clock later, with rsp_rdata holding the register value in the request cycle. A write request produces no response.
- R3: The register index is byte offset >> 3, using the offset map in the description. Only offsets with bits [2:0] = 0 can decode to a register.
- R4: A read of any unmapped offset, including 0x00, 0x1C, 0x68 and 0xFF8, returns 64'hFFFF_FFFF_FFFF_FFFF.
- R5: A write to an unmapped offset changes no register.
- R6: A write to the control or scratch word stores the full 64-bit data.
- R7: Writes to a read-only word are ignored. The identification and capability words stay constant. The live status word takes hw_live_status on every clock.
- R8: A write to a status A/B word clears exactly the bits that are 1 in the written data and keeps all other bits.
- R9: hw_stat_a_set and hw_stat_b_set are ORed into their status words every clock. When a set and a software clear hit the same bit in one cycle, the bit ends up set.
- R10: Any write to the secondary status word or a log word sets that word to zero, whatever the data. hw_sec_set ORs into the secondary word, and hw_log_load loads hw_log_word0/1 into log words 0/1. If a hardware update meets a write in the same cycle, the hardware value remains.
- R11: A write to the masked field word stores wdata & FIELD_MASK (default 64'h0000_0000_00FF_0F0F).
- R12: A write to the trap word stores zero, whatever the data. hw_trap_load loads hw_trap_data into it, but a write in the same cycle wins and leaves zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| hw_stat_a_set | input | 64 | Sticky set bits for status A |
| hw_stat_b_set | input | 64 | Sticky set bits for status B |
| hw_sec_set | input | 64 | Sticky set bits for secondary status |
| hw_log_load | input | 1 | Load both log words |
| hw_log_word0 | input | 64 | Value for log word 0 |
| hw_log_word1 | input | 64 | Value for log word 1 |
| hw_trap_load | input | 1 | Load the trap word |
| hw_trap_data | input | 64 | Value for the trap word |
| hw_live_status | input | 64 | Live status mirrored into a read-only word |

## Verification
The assertions assume that the bus carries at most one request per cycle and that every input is held at a defined value from time zero, reset included. The past-value checks rely on write enables being low during reset. The bench drives all inputs to zero before releasing reset and changes them only on falling edges. Each request is kept for exactly one cycle, and hardware pulses last one cycle unless a same-cycle collision with a write is being exercised on purpose.

// File: rtl/errcsr_pkg.sv
package errcsr_pkg;

    localparam int DATA_W = 64;
    localparam int SLOT_N = 16;

    typedef enum logic [2:0] {
        POL_NONE,
        POL_RW,
        POL_RO,
        POL_W1C,
        POL_WXC,
        POL_MASK,
        POL_WZERO
    } policy_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

    localparam int IX_ID      = 1;
    localparam int IX_CAP     = 2;
    localparam int IX_CTRL    = 3;
    localparam int IX_SCRATCH = 4;
    localparam int IX_STAT_A  = 5;
    localparam int IX_STAT_B  = 6;
    localparam int IX_SEC     = 7;
    localparam int IX_LOG0    = 8;
    localparam int IX_LOG1    = 9;
    localparam int IX_FIELD   = 10;
    localparam int IX_TRAP    = 11;
    localparam int IX_LIVE    = 12;

    function automatic policy_e policy_of(input int ix);
        policy_e p;
        case (ix)
            IX_ID, IX_CAP, IX_LIVE:  p = POL_RO;
            IX_CTRL, IX_SCRATCH:     p = POL_RW;
            IX_STAT_A, IX_STAT_B:    p = POL_W1C;
            IX_SEC, IX_LOG0, IX_LOG1: p = POL_WXC;
            IX_FIELD:                p = POL_MASK;
            IX_TRAP:                 p = POL_WZERO;
            default:                 p = POL_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/errcsr_decode.sv
module errcsr_decode
    import errcsr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SLOTS  = SLOT_N,
    localparam int IDX_W  = ADDR_W - 3,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit,
    output logic [SLOT_W-1:0] idx,
    output logic              rd_req,
    output logic [SLOTS-1:0]  wr_sel
);

    logic [IDX_W-1:0] word_ix;

    assign word_ix = req_addr[ADDR_W-1:3];
    assign rd_req  = req_valid && !req_write;

    always_comb begin
        hit = 1'b0;
        idx = '0;
        if ((req_addr[2:0] == 3'b000) && (word_ix < IDX_W'(SLOTS))) begin
            idx = word_ix[SLOT_W-1:0];
            hit = (policy_of(int'(word_ix)) != POL_NONE);
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_sel
        assign wr_sel[i] = req_valid && req_write && hit && (idx == SLOT_W'(i));
    end

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R5
    miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (wr_sel == '0));

endmodule

// File: rtl/errcsr_slot.sv
module errcsr_slot
    import errcsr_pkg::*;
#(
    parameter int                 WIDTH      = DATA_W,
    parameter policy_e            POLICY     = POL_RW,
    parameter logic [WIDTH-1:0]   RESET_VAL  = '0,
    parameter logic [WIDTH-1:0]   FIELD_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] hw_set,
    input  logic             hw_load,
    input  logic [WIDTH-1:0] hw_load_val,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_nxt;
    logic             unused_ports;

    assign unused_ports = ^{wr_en, wdata, hw_set, hw_load, hw_load_val};

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= q_nxt;
    end

    if (POLICY == POL_RW) begin : g_rw
        assign q_nxt = wr_en ? wdata : q;
        // R6
        rw_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en) |-> (q == $past(wdata)));
    end else if (POLICY == POL_RO) begin : g_ro
        assign q_nxt = hw_load ? hw_load_val : q;
        // R7
        ro_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en && !hw_load) |-> $stable(q));
    end else if (POLICY == POL_W1C) begin : g_w1c
        assign q_nxt = (q & ~(wr_en ? wdata : '0)) | hw_set;
        // R8
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en) |-> ((q & $past(wdata) & ~$past(hw_set)) == '0));
        // R9
        w1c_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((q & $past(hw_set)) == $past(hw_set)));
    end else if (POLICY == POL_WXC) begin : g_wxc
        assign q_nxt = hw_load ? hw_load_val : ((wr_en ? '0 : q) | hw_set);
        // R10
        wxc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en && !hw_load && (hw_set == '0)) |-> (q == '0));
        // R10
        wxc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(hw_load) |-> (q == $past(hw_load_val)));
    end else if (POLICY == POL_MASK) begin : g_mask
        assign q_nxt = wr_en ? (wdata & FIELD_MASK) : q;
        // R11
        mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en) |-> (q == ($past(wdata) & FIELD_MASK)));
    end else if (POLICY == POL_WZERO) begin : g_wzero
        assign q_nxt = wr_en ? '0 : (hw_load ? hw_load_val : q);
        // R12
        wzero_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en) |-> (q == '0));
    end else begin : g_none
        assign q_nxt = RESET_VAL;
    end

endmodule

// File: rtl/errcsr_rdmux.sv
module errcsr_rdmux
    import errcsr_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int SLOTS = SLOT_N,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0][WIDTH-1:0] regs,
    input  logic                        hit,
    input  logic [SLOT_W-1:0]           idx,
    output logic [WIDTH-1:0]            rd_word
);

    always_comb begin
        rd_word = '1;
        if (hit) rd_word = regs[idx];
    end

endmodule

// File: rtl/errcsr_bus_fsm.sv
module errcsr_bus_fsm
    import errcsr_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [WIDTH-1:0] rd_word,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_rdata
);

    bus_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            BUS_IDLE: state_nxt = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_nxt = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (rd_req) rsp_rdata <= rd_word;
    end

    assign rsp_valid = (state == BUS_RESP);

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_req));

    // R2
    read_gets_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);

endmodule

// File: rtl/errcsr_file.sv
module errcsr_file
    import errcsr_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [63:0]     ID_WORD    = 64'h4552_5243_0001_0002,
    parameter logic [63:0]     CAP_WORD   = 64'h0000_0000_0000_0C1F,
    parameter logic [63:0]     FIELD_MASK = 64'h0000_0000_00FF_0F0F,
    localparam int             SLOT_W     = $clog2(SLOT_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    input  logic [63:0]       hw_stat_a_set,
    input  logic [63:0]       hw_stat_b_set,
    input  logic [63:0]       hw_sec_set,
    input  logic              hw_log_load,
    input  logic [63:0]       hw_log_word0,
    input  logic [63:0]       hw_log_word1,
    input  logic              hw_trap_load,
    input  logic [63:0]       hw_trap_data,
    input  logic [63:0]       hw_live_status
);

    function automatic logic [DATA_W-1:0] reset_of(input int ix);
        if (ix == IX_ID)  return ID_WORD;
        if (ix == IX_CAP) return CAP_WORD;
        return '0;
    endfunction

    logic                           hit;
    logic [SLOT_W-1:0]              idx;
    logic                           rd_req;
    logic [SLOT_N-1:0]              wr_sel;
    logic [SLOT_N-1:0][DATA_W-1:0]  slot_q;
    logic [SLOT_N-1:0][DATA_W-1:0]  slot_set;
    logic [SLOT_N-1:0][DATA_W-1:0]  slot_val;
    logic [SLOT_N-1:0]              slot_load;
    logic [DATA_W-1:0]              rd_word;

    errcsr_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOT_N)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .hit       (hit),
        .idx       (idx),
        .rd_req    (rd_req),
        .wr_sel    (wr_sel)
    );

    always_comb begin
        slot_set  = '0;
        slot_val  = '0;
        slot_load = '0;
        slot_set[IX_STAT_A]  = hw_stat_a_set;
        slot_set[IX_STAT_B]  = hw_stat_b_set;
        slot_set[IX_SEC]     = hw_sec_set;
        slot_load[IX_LOG0]   = hw_log_load;
        slot_val[IX_LOG0]    = hw_log_word0;
        slot_load[IX_LOG1]   = hw_log_load;
        slot_val[IX_LOG1]    = hw_log_word1;
        slot_load[IX_TRAP]   = hw_trap_load;
        slot_val[IX_TRAP]    = hw_trap_data;
        slot_load[IX_LIVE]   = 1'b1;
        slot_val[IX_LIVE]    = hw_live_status;
    end

    for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
        errcsr_slot #(
            .WIDTH      (DATA_W),
            .POLICY     (policy_of(i)),
            .RESET_VAL  (reset_of(i)),
            .FIELD_MASK (FIELD_MASK)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_sel[i]),
            .wdata       (req_wdata),
            .hw_set      (slot_set[i]),
            .hw_load     (slot_load[i]),
            .hw_load_val (slot_val[i]),
            .q           (slot_q[i])
        );
    end

    errcsr_rdmux #(.WIDTH(DATA_W), .SLOTS(SLOT_N)) u_rdmux (
        .regs    (slot_q),
        .hit     (hit),
        .idx     (idx),
        .rd_word (rd_word)
    );

    errcsr_bus_fsm #(.WIDTH(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_word   (rd_word),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // R4
    unmapped_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req && !hit) |-> (rsp_rdata == '1));

endmodule

// File: tb/errcsr_file_test.sv
module errcsr_file_test;

    localparam logic [63:0] ID_EXP   = 64'h4552_5243_0001_0002;
    localparam logic [63:0] CAP_EXP  = 64'h0000_0000_0000_0C1F;
    localparam logic [63:0] MASK_EXP = 64'h0000_0000_00FF_0F0F;
    localparam logic [63:0] ONES     = 64'hFFFF_FFFF_FFFF_FFFF;

    localparam logic [11:0] A_ID = 12'h008, A_CAP = 12'h010, A_CTRL = 12'h018,
        A_SCR = 12'h020, A_STA = 12'h028, A_STB = 12'h030, A_SEC = 12'h038,
        A_LOG0 = 12'h040, A_LOG1 = 12'h048, A_FLD = 12'h050, A_TRAP = 12'h058,
        A_LIVE = 12'h060;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [63:0] hw_stat_a_set = '0, hw_stat_b_set = '0, hw_sec_set = '0;
    logic        hw_log_load = 1'b0, hw_trap_load = 1'b0;
    logic [63:0] hw_log_word0 = '0, hw_log_word1 = '0, hw_trap_data = '0;
    logic [63:0] hw_live_status = '0;

    int tests_run = 0;
    int tests_failed = 0;
    logic [63:0] d;

    always #4 clk = ~clk;

    errcsr_file uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .hw_stat_a_set(hw_stat_a_set),
        .hw_stat_b_set(hw_stat_b_set), .hw_sec_set(hw_sec_set),
        .hw_log_load(hw_log_load), .hw_log_word0(hw_log_word0),
        .hw_log_word1(hw_log_word1), .hw_trap_load(hw_trap_load),
        .hw_trap_data(hw_trap_data), .hw_live_status(hw_live_status)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests_run++;
        if (got !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [63:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [63:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        v = rsp_rdata;
    endtask

    task automatic t_reset;
        check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        bus_read(A_ID, d);   check("R1 id word", d, ID_EXP);
        bus_read(A_CAP, d);  check("R1 cap word", d, CAP_EXP);
        bus_read(A_CTRL, d); check("R1 ctrl zero", d, 64'd0);
        bus_read(A_STA, d);  check("R1 status A zero", d, 64'd0);
        bus_read(A_LOG0, d); check("R1 log0 zero", d, 64'd0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        check("R2 idle no rsp", {63'd0, rsp_valid}, 64'd0);
        bus_write(A_SCR, 64'h55);
        check("R2 write no rsp", {63'd0, rsp_valid}, 64'd0);
        bus_read(A_SCR, d);
        check("R2 read data", d, 64'h55);
        @(negedge clk);
        check("R2 rsp drops", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_rw;
        bus_write(A_CTRL, 64'hDEAD_BEEF_0123_4567);
        bus_write(A_SCR,  64'hFEDC_BA98_7654_3210);
        bus_read(A_CTRL, d); check("R6 R3 ctrl store", d, 64'hDEAD_BEEF_0123_4567);
        bus_read(A_SCR, d);  check("R6 R3 scratch store", d, 64'hFEDC_BA98_7654_3210);
    endtask

    task automatic t_unmapped;
        bus_read(12'h000, d); check("R4 offset 0x0", d, ONES);
        bus_read(12'h068, d); check("R4 offset 0x68", d, ONES);
        bus_read(12'h01C, d); check("R4 unaligned 0x1C", d, ONES);
        bus_read(12'hFF8, d); check("R4 offset 0xFF8", d, ONES);
        bus_write(12'h000, 64'h1111);
        bus_write(12'h01C, 64'h2222);
        bus_write(12'h070, 64'h3333);
        bus_read(A_CTRL, d); check("R5 ctrl untouched", d, 64'hDEAD_BEEF_0123_4567);
        bus_read(A_SCR, d);  check("R5 scratch untouched", d, 64'hFEDC_BA98_7654_3210);
    endtask

    task automatic t_ro;
        bus_write(A_ID, 64'd0);
        bus_read(A_ID, d);  check("R7 id ignores write", d, ID_EXP);
        bus_write(A_CAP, ONES);
        bus_read(A_CAP, d); check("R7 cap ignores write", d, CAP_EXP);
        @(negedge clk); hw_live_status = 64'hABC0_0000_0000_0ABC;
        bus_write(A_LIVE, 64'd0);
        bus_read(A_LIVE, d); check("R7 live mirror", d, 64'hABC0_0000_0000_0ABC);
    endtask

    task automatic t_w1c;
        @(negedge clk); hw_stat_a_set = 64'h00FF_00FF;
        @(negedge clk); hw_stat_a_set = '0;
        bus_read(A_STA, d); check("R9 status A set", d, 64'h00FF_00FF);
        bus_write(A_STA, 64'h000F_000F);
        bus_read(A_STA, d); check("R8 W1C partial clear", d, 64'h00F0_00F0);
        @(negedge clk); hw_stat_b_set = 64'h8000_0000_0000_0001;
        @(negedge clk); hw_stat_b_set = '0;
        bus_write(A_STB, 64'd0);
        bus_read(A_STB, d); check("R8 zero write keeps bits", d, 64'h8000_0000_0000_0001);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = A_STA; req_wdata = ONES;
        hw_stat_a_set = 64'h0000_0010;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; hw_stat_a_set = '0;
        bus_read(A_STA, d); check("R9 set beats clear", d, 64'h0000_0010);
    endtask

    task automatic t_wxc;
        @(negedge clk); hw_sec_set = 64'h5;
        @(negedge clk); hw_sec_set = '0;
        bus_read(A_SEC, d); check("R10 sec set", d, 64'h5);
        bus_write(A_SEC, 64'd0);
        bus_read(A_SEC, d); check("R10 sec clear on zero write", d, 64'd0);
        @(negedge clk);
        hw_log_load = 1'b1; hw_log_word0 = 64'h1234_5678; hw_log_word1 = 64'h9ABC_DEF0;
        @(negedge clk); hw_log_load = 1'b0;
        bus_write(A_LOG0, 64'hFFFF);
        bus_read(A_LOG0, d); check("R10 log0 cleared", d, 64'd0);
        bus_read(A_LOG1, d); check("R10 log1 kept", d, 64'h9ABC_DEF0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = A_SEC; req_wdata = ONES;
        hw_sec_set = 64'h8;
        @(negedge clk);
        req_addr = A_LOG1; hw_sec_set = '0;
        hw_log_load = 1'b1; hw_log_word0 = 64'h77; hw_log_word1 = 64'h4242;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; hw_log_load = 1'b0;
        bus_read(A_SEC, d);  check("R10 sec set beats write", d, 64'h8);
        bus_read(A_LOG1, d); check("R10 load beats write", d, 64'h4242);
    endtask

    task automatic t_mask;
        bus_write(A_FLD, ONES);
        bus_read(A_FLD, d); check("R11 masked all ones", d, MASK_EXP);
        bus_write(A_FLD, 64'hFFFF_0000_0012_3456);
        bus_read(A_FLD, d); check("R11 masked pattern", d, 64'h0000_0000_0012_0406);
    endtask

    task automatic t_wzero;
        @(negedge clk); hw_trap_load = 1'b1; hw_trap_data = 64'h77;
        @(negedge clk); hw_trap_load = 1'b0;
        bus_read(A_TRAP, d); check("R12 trap load", d, 64'h77);
        bus_write(A_TRAP, 64'h1234);
        bus_read(A_TRAP, d); check("R12 write stores zero", d, 64'd0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = A_TRAP; req_wdata = 64'h99;
        hw_trap_load = 1'b1; hw_trap_data = 64'h55;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; hw_trap_load = 1'b0;
        bus_read(A_TRAP, d); check("R12 write beats load", d, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL R2 watchdog actual=hung expected=complete");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_rw();
        t_unmapped();
        t_ro();
        t_w1c();
        t_set_wins();
        t_wxc();
        t_mask();
        t_wzero();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule